// File: doc/BRIEF.md
# Interleave Address Channel Dehash Unit

This unit undoes an XOR channel-select hash that was folded into the low interleave bits of a normalized physical address. Those bits start at position 8. Each interleave bit is XOR-combined with up to three higher address bits, at offsets of +8, +13 and +22 from the interleave bit. Each of the three terms is switched on by its own granularity enable: 64 KiB, 2 MiB and 1 GiB. The mode code sets the channel count, and the channel count sets how many interleave bits are hashed.

A request is captured when `in_valid` is high. One clock later the unit presents the dehashed address, the decoded channel count and an error flag, together with `out_valid`. If the mode code is not supported, or the interleave configuration is not supported, the error flag is raised and the address passes through unchanged.

Top module: `dehash_unit`

## Requirements
- R1: While reset is asserted, and after it, until the first accepted request, `out_valid`, `out_err`, `out_chan` and `out_addr` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. When `in_valid` is low, `out_addr`, `out_chan` and `out_err` keep their values.
- R3: `out_chan` reports the decoded channel count. Mode 0x1C gives 8 channels and hashes 3 bits (8..10). Mode 0x1D gives 16 channels and hashes 4 bits (8..11). Mode 0x1E gives 32 channels and hashes 5 bits (8..12). Any other code gives 0. The channel count is reported even when the configuration is in error.
- R4: On an error-free request, for every hashed bit index i, output bit 8+i equals input bit 8+i XOR (en64k AND in[16+i]) XOR (en2m AND in[21+i]) XOR (en1g AND in[30+i]). Every term is taken from the unmodified input address.
- R5: On every request, address bits below 8 pass to the output unchanged. So do bits above the hashed range, including bits 11 and 12 in modes that do not hash them.
- R6: When all three hash enables are low, the output address equals the input address.
- R7: A mode code other than 0x1C, 0x1D or 0x1E sets `out_err` to 1, sets `out_chan` to 0 and passes the address through unchanged.
- R8: An interleave bit position other than 8 sets `out_err` to 1 and passes the address through unchanged.
- R9: A die interleave count above 1, or a socket interleave count above 1, sets `out_err` to 1 and passes the address through unchanged. Counts of 0 and 1 are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_addr | input | 64 | Hashed normalized address |
| in_mode | input | 8 | Interleave mode code |
| hash_en_64k | input | 1 | Enables the +8 term (bit 16+i) |
| hash_en_2m | input | 1 | Enables the +13 term (bit 21+i) |
| hash_en_1g | input | 1 | Enables the +22 term (bit 30+i) |
| in_intlv_pos | input | 6 | Interleave start bit position |
| in_num_dies | input | 4 | Number of interleaved dies |
| in_num_sockets | input | 4 | Number of interleaved sockets |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_addr | output | 64 | Dehashed address |
| out_chan | output | 6 | Decoded channel count |
| out_err | output | 1 | Unsupported mode or configuration |

## Verification
Folding and error suppression can act on the same request. The bench provokes this by sending requests that have every hash enable set and high address bits populated, combined with a wrong bit position, a die or socket count above 1, or an unknown mode. The result is judged correct only if the address comes back bit-for-bit unchanged while the error flag is set. Mode decoding and the config check also coincide: the bench checks that a config fault still reports the channel count of a valid mode.

// File: rtl/dehash_pkg.sv
package dehash_pkg;
  // Mode codes; the values are decoded externally, so they are fixed.
  localparam logic [7:0] MODE_CH8  = 8'h1C;
  localparam logic [7:0] MODE_CH16 = 8'h1D;
  localparam logic [7:0] MODE_CH32 = 8'h1E;

  // Position of the first interleave bit and offsets of the fold terms.
  localparam int SEL_BASE   = 8;
  localparam int TAP_64K    = 16;
  localparam int TAP_2M     = 21;
  localparam int TAP_1G     = 30;

  // Largest number of hashed bits across supported modes.
  localparam int MAX_HB     = 5;
  localparam int NB_W       = $clog2(MAX_HB + 1);
  localparam int CHAN_W     = 6;

  typedef struct packed {
    logic              ok;
    logic [CHAN_W-1:0] chan;
    logic [NB_W-1:0]   nbits;
  } mode_info_t;
endpackage

// File: rtl/dehash_mode_decode.sv
module dehash_mode_decode
  import dehash_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic [MODE_W-1:0] mode,
  output mode_info_t        info
);
  always_comb begin
    info = '0;
    unique case (mode)
      MODE_W'(MODE_CH8): begin
        info.ok    = 1'b1;
        info.chan  = CHAN_W'(8);
        info.nbits = NB_W'(3);
      end
      MODE_W'(MODE_CH16): begin
        info.ok    = 1'b1;
        info.chan  = CHAN_W'(16);
        info.nbits = NB_W'(4);
      end
      MODE_W'(MODE_CH32): begin
        info.ok    = 1'b1;
        info.chan  = CHAN_W'(32);
        info.nbits = NB_W'(5);
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/dehash_cfg_check.sv
module dehash_cfg_check
  import dehash_pkg::*;
#(
  parameter int POS_W = 6,
  parameter int CNT_W = 4
) (
  input  logic [POS_W-1:0] intlv_pos,
  input  logic [CNT_W-1:0] num_dies,
  input  logic [CNT_W-1:0] num_sockets,
  output logic             cfg_bad
);
  logic pos_bad, die_bad, sock_bad;

  always_comb begin
    pos_bad  = (intlv_pos != POS_W'(SEL_BASE));
    die_bad  = (num_dies > CNT_W'(1));
    sock_bad = (num_sockets > CNT_W'(1));
    cfg_bad  = pos_bad | die_bad | sock_bad;
  end
endmodule

// File: rtl/dehash_fold.sv
module dehash_fold
  import dehash_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NB_W-1:0]   nbits,
  input  logic              en_64k,
  input  logic              en_2m,
  input  logic              en_1g,
  output logic [MAX_HB-1:0] flip
);
  // Each flip bit uses only the original address, so bit order is irrelevant.
  for (genvar i = 0; i < MAX_HB; i++) begin : g_bit
    localparam logic [NB_W-1:0] IDX = NB_W'(i);
    logic term_64k, term_2m, term_1g, active;
    always_comb begin
      active   = (IDX < nbits);
      term_64k = en_64k & addr[TAP_64K + i];
      term_2m  = en_2m  & addr[TAP_2M + i];
      term_1g  = en_1g  & addr[TAP_1G + i];
      flip[i]  = active & (term_64k ^ term_2m ^ term_1g);
    end
  end
endmodule

// File: rtl/dehash_unit.sv
module dehash_unit
  import dehash_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MODE_W = 8,
  parameter int POS_W  = 6,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              hash_en_64k,
  input  logic              hash_en_2m,
  input  logic              hash_en_1g,
  input  logic [POS_W-1:0]  in_intlv_pos,
  input  logic [CNT_W-1:0]  in_num_dies,
  input  logic [CNT_W-1:0]  in_num_sockets,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CHAN_W-1:0] out_chan,
  output logic              out_err
);
  mode_info_t        minfo;
  logic              cfg_bad;
  logic [MAX_HB-1:0] flip;
  logic [ADDR_W-1:0] flip_wide;
  logic [ADDR_W-1:0] addr_nxt;
  logic [CHAN_W-1:0] chan_nxt;
  logic              err_nxt;
  logic              valid_nxt;

  dehash_mode_decode #(.MODE_W(MODE_W)) u_mode (
    .mode (in_mode),
    .info (minfo)
  );

  dehash_cfg_check #(.POS_W(POS_W), .CNT_W(CNT_W)) u_cfg (
    .intlv_pos   (in_intlv_pos),
    .num_dies    (in_num_dies),
    .num_sockets (in_num_sockets),
    .cfg_bad     (cfg_bad)
  );

  dehash_fold #(.ADDR_W(ADDR_W)) u_fold (
    .addr   (in_addr),
    .nbits  (minfo.nbits),
    .en_64k (hash_en_64k),
    .en_2m  (hash_en_2m),
    .en_1g  (hash_en_1g),
    .flip   (flip)
  );

  always_comb begin
    flip_wide = ADDR_W'(flip) << SEL_BASE;
    err_nxt   = cfg_bad | ~minfo.ok;
    addr_nxt  = err_nxt ? in_addr : (in_addr ^ flip_wide);
    chan_nxt  = minfo.chan;
    valid_nxt = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_chan <= '0;
      out_err  <= 1'b0;
    end else if (in_valid) begin
      out_addr <= addr_nxt;
      out_chan <= chan_nxt;
      out_err  <= err_nxt;
    end
  end
endmodule

// File: rtl/dehash_chk.sv
module dehash_chk
  import dehash_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MODE_W = 8,
  parameter int POS_W  = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [MODE_W-1:0] in_mode,
  input logic              hash_en_64k,
  input logic              hash_en_2m,
  input logic              hash_en_1g,
  input logic [POS_W-1:0]  in_intlv_pos,
  input logic [CNT_W-1:0]  in_num_dies,
  input logic [CNT_W-1:0]  in_num_sockets,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [CHAN_W-1:0] out_chan,
  input logic              out_err
);
  logic mode_known;
  assign mode_known = (in_mode == MODE_W'(MODE_CH8)) || (in_mode == MODE_W'(MODE_CH16)) ||
                      (in_mode == MODE_W'(MODE_CH32));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid) else $error("valid"); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid) else $error("drop"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_addr) && $stable(out_err) && $stable(out_chan))) else $error("hold"); // R2
  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_addr[SEL_BASE-1:0] == $past(in_addr[SEL_BASE-1:0]) &&
                  out_addr[ADDR_W-1:SEL_BASE+MAX_HB] == $past(in_addr[ADDR_W-1:SEL_BASE+MAX_HB]))) else $error("pass"); // R5
  AST_NO_ENABLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !hash_en_64k && !hash_en_2m && !hash_en_1g) |=> (out_addr == $past(in_addr))) else $error("noen"); // R6
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_known) |=> (out_err && out_chan == '0 && out_addr == $past(in_addr))) else $error("mode"); // R7
  AST_BAD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_intlv_pos != POS_W'(SEL_BASE)) |=> (out_err && out_addr == $past(in_addr))) else $error("pos"); // R8
  AST_BAD_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_num_dies > CNT_W'(1) || in_num_sockets > CNT_W'(1))) |=> (out_err && out_addr == $past(in_addr))) else $error("spread"); // R9
endmodule

bind dehash_unit dehash_chk #(
  .ADDR_W(ADDR_W), .MODE_W(MODE_W), .POS_W(POS_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_dehash_unit.sv
`timescale 1ns/1ps
module tb_dehash_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_addr;
  logic [7:0]  in_mode;
  logic        hash_en_64k, hash_en_2m, hash_en_1g;
  logic [5:0]  in_intlv_pos;
  logic [3:0]  in_num_dies, in_num_sockets;
  logic        out_valid;
  logic [63:0] out_addr;
  logic [5:0]  out_chan;
  logic        out_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  dehash_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode),
    .hash_en_64k(hash_en_64k), .hash_en_2m(hash_en_2m), .hash_en_1g(hash_en_1g),
    .in_intlv_pos(in_intlv_pos), .in_num_dies(in_num_dies), .in_num_sockets(in_num_sockets),
    .out_valid(out_valid), .out_addr(out_addr), .out_chan(out_chan), .out_err(out_err)
  );

  function automatic int exp_nbits(input logic [7:0] m);
    case (m)
      8'h1C: return 3;
      8'h1D: return 4;
      8'h1E: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [5:0] exp_chan(input logic [7:0] m);
    case (m)
      8'h1C: return 6'd8;
      8'h1D: return 6'd16;
      8'h1E: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic exp_err(input logic [7:0] m, input logic [5:0] p,
                                   input logic [3:0] d, input logic [3:0] s);
    return (exp_nbits(m) == 0) || (p != 6'd8) || (d > 4'd1) || (s > 4'd1);
  endfunction

  function automatic logic [63:0] exp_addr(input logic [63:0] a, input logic [7:0] m,
                                           input logic e1, input logic e2, input logic e3,
                                           input logic err);
    logic [63:0] r;
    r = a;
    if (!err)
      for (int i = 0; i < exp_nbits(m); i++)
        r[8+i] = a[8+i] ^ (e1 & a[16+i]) ^ (e2 & a[21+i]) ^ (e3 & a[30+i]);
    return r;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request, then check at the following falling edge.
  task automatic send(input string req, input logic [63:0] a, input logic [7:0] m,
                      input logic e1, input logic e2, input logic e3,
                      input logic [5:0] p, input logic [3:0] d, input logic [3:0] s);
    logic        ee;
    logic [63:0] ea;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_mode = m;
    hash_en_64k = e1; hash_en_2m = e2; hash_en_1g = e3;
    in_intlv_pos = p; in_num_dies = d; in_num_sockets = s;
    ee = exp_err(m, p, d, s);
    ea = exp_addr(a, m, e1, e2, e3, ee);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R2"}, out_valid == 1'b1, 64'(out_valid), 64'd1);
    check({req, " addr"}, out_addr == ea, out_addr, ea);
    check({req, " err"}, out_err == ee, 64'(out_err), 64'(ee));
    check({req, " chan R3"}, out_chan == exp_chan(m), 64'(out_chan), 64'(exp_chan(m)));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_a;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_mode = '0;
    hash_en_64k = 0; hash_en_2m = 0; hash_en_1g = 0;
    in_intlv_pos = 6'd8; in_num_dies = 0; in_num_sockets = 0;
    #20;
    check("R1 reset valid", out_valid == 0, 64'(out_valid), 0);
    check("R1 reset outs", out_addr == 0 && out_err == 0 && out_chan == 0, out_addr, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset idle", out_valid == 0 && out_addr == 0, out_addr, 0);

    // Directed: single-term folds per mode
    send("R4 64k bit16", 64'h1_0000, 8'h1C, 1, 0, 0, 8, 1, 1);
    check("R4 64k flips bit8", out_addr == 64'h1_0100, out_addr, 64'h1_0100);
    send("R4 2m bit21", 64'h20_0000, 8'h1C, 0, 1, 0, 8, 0, 0);
    send("R4 1g bit34", 64'h4_0000_0000, 8'h1E, 0, 0, 1, 8, 1, 0);
    check("R4 1g flips bit12", out_addr == 64'h4_0000_1000, out_addr, 64'h4_0000_1000);
    send("R4 all terms", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1D, 1, 1, 1, 8, 0, 1);
    // R5: 8-channel mode leaves bits 11/12 alone even with taps set
    send("R5 bits 11-12 kept", 64'h0000_0018_0018_0000, 8'h1C, 1, 1, 1, 8, 0, 0);
    check("R5 upper untouched", out_addr[12:11] == 2'b00, 64'(out_addr[12:11]), 0);
    send("R6 no enables", 64'hDEAD_BEEF_CAFE_F00D, 8'h1E, 0, 0, 0, 8, 0, 0);
    check("R6 identity", out_addr == 64'hDEAD_BEEF_CAFE_F00D, out_addr, 64'hDEAD_BEEF_CAFE_F00D);
    // Error overlap with active folding
    send("R7 bad mode", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1F, 1, 1, 1, 8, 0, 0);
    send("R7 mode zero", 64'h1234_5678_9ABC_DEF0, 8'h00, 1, 1, 1, 8, 0, 0);
    send("R8 pos 9", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1E, 1, 1, 1, 9, 0, 0);
    send("R8 pos 0", 64'h0000_0007_FFFF_0000, 8'h1C, 1, 0, 0, 0, 0, 0);
    send("R9 dies 2", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1D, 1, 1, 1, 8, 2, 0);
    send("R9 sockets 2", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1D, 1, 1, 1, 8, 1, 2);
    send("R9 sockets 15", 64'hFFFF_FFFF_FFFF_FFFF, 8'h1C, 1, 0, 1, 8, 0, 15);

    // R2 hold: idle cycles keep the last result
    held_a = out_addr;
    @(negedge clk);
    check("R2 idle no valid", out_valid == 0, 64'(out_valid), 0);
    in_addr = ~in_addr; in_mode = 8'h1E;
    @(negedge clk);
    check("R2 hold addr", out_addr == held_a && out_err == 1'b1, out_addr, held_a);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      logic [7:0]  m;
      logic [5:0]  p;
      logic [3:0]  d, s;
      int r;
      a = {$urandom(), $urandom()};
      r = $urandom_range(0, 9);
      m = (r < 3) ? 8'h1C : (r < 6) ? 8'h1D : (r < 9) ? 8'h1E : 8'($urandom());
      p = ($urandom_range(0, 7) == 0) ? 6'($urandom()) : 6'd8;
      d = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'($urandom_range(0, 1));
      s = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'($urandom_range(0, 1));
      send("R4 random", a, m, 1'($urandom()), 1'($urandom()), 1'($urandom()), p, d, s);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule